// File: doc/BRIEF.md
# Half-Bridge Gate Sequencer with Fault Latch

This block is the digital control core of a half-bridge gate driver. It accepts two asynchronous logic commands, one per switch (high side and low side), and brings each across the clock boundary. A glitch filter then has to confirm each command before the block drives a gate-enable output for the matching switch. Every handover passes through a fixed dead interval with both enables low, so the two switches never conduct at the same time.

The high-side floating supply is recharged only while the low side conducts. For that reason the block tracks how long the high side has gone without a low-side interval. When that time reaches the refresh period, it cuts the high side, waits the dead time, pulses the low side for a short fixed time, waits the dead time again and then gives control back to the high-side command. Any low-side conduction restarts this timer, so ordinary fast switching never triggers a forced pulse.

Three digital status inputs can latch a fault, which drops both enables: bias undervoltage, overcurrent, and a sensed output phase that disagrees with the driven state outside a blanking window. The fault clears only at reset, or after both commands have stayed low for a set time. A boost request is captured between conduction pulses and presented as a one-bit threshold select to the external overcurrent comparator. All timings are parameters counted in clock cycles.

Top module: `hb_gate_seq`

## Requirements
- R1: With only the high-side command asserted, `hs_gate_en` is 1 and `ls_gate_en` is 0. With only the low-side command asserted, the opposite holds. With neither asserted, both enables are 0.
- R2: A command level must persist for FILT_LEN (default 4) consecutive clocks after synchronisation before it is accepted. A pulse of FILT_LEN-1 clocks produces no enable pulse.
- R3: The two enables are never 1 in the same cycle. After either enable falls, both stay 0 for at least DEAD_CYC cycles before either enable rises.
- R4: While the high side is commanded continuously, no high-side conduction stint lasts longer than REFRESH_CYC cycles. Each stint is followed by a forced low-side pulse of exactly REFR_ON_CYC cycles, with dead time on both sides, after which the high side resumes.
- R5: With both commands asserted together, both enables are 0 and no fault is raised.
- R6: Any low-side conduction restarts the refresh timer. If the low side is commanded more often than once per REFRESH_CYC, no forced low-side pulse occurs.
- R7: A bias-undervoltage or overcurrent input latches `fault` = 1, and the fault stays latched after the cause goes away.
- R8: While `fault` is 1, both enables are 0 whatever the commands are.
- R9: A latched fault clears only when both filtered commands stay low for FRST_CYC consecutive cycles. A shorter low interval leaves the fault set.
- R10: A phase mismatch latches the fault: `hs_gate_en` = 1 with `phase_fb` = 0, or `ls_gate_en` = 1 with `phase_fb` = 1. A mismatch inside the BLANK_CYC cycles after any enable change is ignored.
- R11: `thr_sel` takes the value of `trip_boost` while both enables are 0 and stays constant for the whole of each conduction pulse.
- R12: After reset, `hs_gate_en`, `ls_gate_en`, `fault` and `thr_sel` are all 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| hs_cmd | input | 1 | High-side command, asynchronous |
| ls_cmd | input | 1 | Low-side command, asynchronous |
| bias_low | input | 1 | Bias undervoltage status, 1 = low |
| ovc_trip | input | 1 | Overcurrent comparator output, 1 = trip |
| phase_fb | input | 1 | Sensed output phase, 1 = output high |
| trip_boost | input | 1 | Request for the raised overcurrent threshold |
| hs_gate_en | output | 1 | High-side gate enable |
| ls_gate_en | output | 1 | Low-side gate enable |
| fault | output | 1 | Latched fault flag |
| thr_sel | output | 1 | Threshold select to comparator, 1 = raised |

## Verification
The hardest situation to reach from the ports is the phase blanking window, because it requires a mismatch that lasts only as long as the turn-on transient. The bench models the output node as a register that follows the enables, and it can pin that node low. It pins the node low before raising the high-side command, waits until it sees `hs_gate_en` rise, and releases the node ten cycles later, still inside the window. It then confirms that no fault is raised. Pinning the node again during a steady high-side stint must then trip the fault. Refresh behaviour is measured by classifying every low-side pulse as forced or commanded according to the command level when the pulse began.

// File: rtl/hbg_pkg.sv
// Shared types for the half-bridge gate sequencer.
package hbg_pkg;

    // Sequencer state: which switch conducts, or which refresh phase runs.
    typedef enum logic [2:0] {
        ST_IDLE = 3'd0,   // both off (dead interval or no request)
        ST_HI   = 3'd1,   // high side conducting
        ST_LO   = 3'd2,   // low side conducting on command
        ST_RGAP = 3'd3,   // dead gap before a forced refresh pulse
        ST_RLO  = 3'd4    // forced low-side refresh pulse
    } seq_st_e;

    // Resolved request after fault and conflict gating.
    typedef enum logic [1:0] {
        RQ_OFF = 2'd0,
        RQ_HI  = 2'd1,
        RQ_LO  = 2'd2
    } req_e;

endpackage

// File: rtl/hbg_sync.sv
// Multi-bit multi-stage synchronizer.
// Assumes each bit is an independent level signal; no bus coherence is implied.
module hbg_sync #(
    parameter int STAGES = 2,
    parameter int W      = 1
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d_async,
    output logic [W-1:0] q_sync
);

    logic [W-1:0] pipe [STAGES];

    // First stage captures the asynchronous inputs.
    always_ff @(posedge clk) begin
        if (!rst_n) pipe[0] <= '0;
        else        pipe[0] <= d_async;
    end

    generate
        for (genvar s = 1; s < STAGES; s++) begin : g_stage
            // Each later stage re-registers the previous one.
            always_ff @(posedge clk) begin
                if (!rst_n) pipe[s] <= '0;
                else        pipe[s] <= pipe[s-1];
            end
        end
    endgenerate

    assign q_sync = pipe[STAGES-1];

endmodule

// File: rtl/hbg_glitch_filter.sv
// Level-confirmation filter: the output follows the input only after the input
// has differed from the output for FILT_LEN consecutive clocks.
// Assumes the input is already synchronous to clk.
module hbg_glitch_filter #(
    parameter int FILT_LEN = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic din,
    output logic dout
);

    localparam int CW = (FILT_LEN > 1) ? $clog2(FILT_LEN) : 1;
    localparam logic [CW-1:0] LAST = CW'(FILT_LEN - 1);

    logic [CW-1:0] run;

    // Count consecutive disagreeing samples; flip the output at the limit.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            dout <= 1'b0;
            run  <= '0;
        end else if (din == dout) begin
            run <= '0;
        end else if (run == LAST) begin
            dout <= din;
            run  <= '0;
        end else begin
            run <= run + 1'b1;
        end
    end

    // R2: an output flip must be preceded by a disagreeing sample the cycle before.
    a_r2_flip_needs_input: assert property (@(posedge clk) disable iff (!rst_n)
        $changed(dout) |-> $past(din) == dout);

endmodule

// File: rtl/hbg_sequencer.sv
// Gate sequencer: resolves the two filtered commands into gate enables,
// inserts a dead interval at every handover and forces low-side refresh
// pulses when the high side goes REFRESH_CYC cycles without low-side conduction.
// Assumes commands are filtered and synchronous; fault is a registered level.
module hbg_sequencer
    import hbg_pkg::*;
#(
    parameter int DEAD_CYC    = 20,
    parameter int REFRESH_CYC = 35000,
    parameter int REFR_ON_CYC = 100
) (
    input  logic clk,
    input  logic rst_n,
    input  logic cmd_hi,
    input  logic cmd_lo,
    input  logic fault,
    output logic hi_en,
    output logic lo_en
);

    localparam int DW = $clog2(DEAD_CYC + 1);
    localparam int TW = $clog2(REFRESH_CYC + 1);
    localparam int PW = $clog2(REFR_ON_CYC + 1);
    localparam logic [DW-1:0] DEAD_LD  = DW'(DEAD_CYC);
    localparam logic [TW-1:0] TMR_LAST = TW'(REFRESH_CYC - 1);
    localparam logic [PW-1:0] PLS_LAST = PW'(REFR_ON_CYC - 1);

    seq_st_e       state;
    req_e          req;
    logic [DW-1:0] dcnt;
    logic [TW-1:0] rtmr;
    logic [PW-1:0] rcnt;

    // Resolve the request: a fault or a conflicting pair means both off.
    always_comb begin
        if (fault || (cmd_hi && cmd_lo)) req = RQ_OFF;
        else if (cmd_hi)                 req = RQ_HI;
        else if (cmd_lo)                 req = RQ_LO;
        else                             req = RQ_OFF;
    end

    // State register with dead counter and refresh pulse counter.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state <= ST_IDLE;
            dcnt  <= '0;
            rcnt  <= '0;
        end else begin
            if (dcnt != '0) dcnt <= dcnt - 1'b1;
            case (state)
                ST_IDLE: begin
                    if (dcnt == '0 && req == RQ_HI)      state <= ST_HI;
                    else if (dcnt == '0 && req == RQ_LO) state <= ST_LO;
                end
                ST_HI: begin
                    if (req != RQ_HI) begin
                        state <= ST_IDLE;
                        dcnt  <= DEAD_LD;
                    end else if (rtmr == TMR_LAST) begin
                        state <= ST_RGAP;
                        dcnt  <= DEAD_LD;
                    end
                end
                ST_LO: begin
                    if (req != RQ_LO) begin
                        state <= ST_IDLE;
                        dcnt  <= DEAD_LD;
                    end
                end
                ST_RGAP: begin
                    if (req == RQ_OFF) begin
                        state <= ST_IDLE;
                    end else if (dcnt == '0) begin
                        state <= ST_RLO;
                        rcnt  <= '0;
                    end
                end
                ST_RLO: begin
                    if (req == RQ_OFF || rcnt == PLS_LAST) begin
                        state <= ST_IDLE;
                        dcnt  <= DEAD_LD;
                    end else begin
                        rcnt <= rcnt + 1'b1;
                    end
                end
                default: state <= ST_IDLE;
            endcase
        end
    end

    // Refresh timer: cleared by any low-side conduction, runs while high side is on.
    always_ff @(posedge clk) begin
        if (!rst_n)                                   rtmr <= '0;
        else if (state == ST_LO || state == ST_RLO)   rtmr <= '0;
        else if (state == ST_HI && rtmr != TMR_LAST)  rtmr <= rtmr + 1'b1;
    end

    assign hi_en = (state == ST_HI);
    assign lo_en = (state == ST_LO) || (state == ST_RLO);

    // Checker-side counters: off-run since last conduction, and high-side stint length.
    logic [DW-1:0] chk_off;
    logic [TW-1:0] chk_hi;

    // Track cycles both enables have been off, saturating at the dead time.
    always_ff @(posedge clk) begin
        if (!rst_n)               chk_off <= DEAD_LD;
        else if (hi_en || lo_en)  chk_off <= '0;
        else if (chk_off != DEAD_LD) chk_off <= chk_off + 1'b1;
    end

    // Track length of the current high-side stint.
    always_ff @(posedge clk) begin
        if (!rst_n)     chk_hi <= '0;
        else if (hi_en) chk_hi <= (chk_hi == '1) ? chk_hi : chk_hi + 1'b1;
        else            chk_hi <= '0;
    end

    a_r3_dead_gap: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(hi_en) || $rose(lo_en)) |-> chk_off >= DEAD_LD);

    a_r3_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(hi_en) |-> $past(!lo_en));

    a_r4_hi_stint: assert property (@(posedge clk) disable iff (!rst_n)
        chk_hi <= TW'(REFRESH_CYC));

    a_r5_conflict_off: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_hi && cmd_lo) |=> (!hi_en && !lo_en));

endmodule

// File: rtl/hbg_fault_ctl.sv
// Fault latch: sets on bias undervoltage, overcurrent or an unblanked phase
// mismatch; clears after both filtered commands stay low for FRST_CYC cycles.
// Assumes all status inputs are synchronous; set has priority over clear.
module hbg_fault_ctl #(
    parameter int BLANK_CYC = 36,
    parameter int FRST_CYC  = 1000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic bias_low,
    input  logic ovc,
    input  logic phase,
    input  logic hi_en,
    input  logic lo_en,
    input  logic cmd_hi,
    input  logic cmd_lo,
    output logic fault
);

    localparam int BW = $clog2(BLANK_CYC + 1);
    localparam int RW = $clog2(FRST_CYC + 1);
    localparam logic [BW-1:0] BLANK_LD = BW'(BLANK_CYC);
    localparam logic [RW-1:0] RST_LAST = RW'(FRST_CYC - 1);

    logic [1:0]    en_prev;
    logic [BW-1:0] blank;
    logic [RW-1:0] low_run;
    logic          both_low;
    logic          mismatch;
    logic          set_f;
    logic          clr_f;

    assign both_low = !cmd_hi && !cmd_lo;

    // Blanking counter: reload on any enable change, then count down.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            en_prev <= 2'b00;
            blank   <= '0;
        end else begin
            en_prev <= {hi_en, lo_en};
            if ({hi_en, lo_en} != en_prev) blank <= BLANK_LD;
            else if (blank != '0)          blank <= blank - 1'b1;
        end
    end

    // Phase disagreement, only once the output has had time to settle.
    always_comb begin
        mismatch = 1'b0;
        if (blank == '0 && {hi_en, lo_en} == en_prev)
            mismatch = (hi_en && !phase) || (lo_en && phase);
    end

    // Count consecutive cycles with both commands low.
    always_ff @(posedge clk) begin
        if (!rst_n || !both_low)   low_run <= '0;
        else if (low_run != RST_LAST) low_run <= low_run + 1'b1;
    end

    assign set_f = bias_low || ovc || mismatch;
    assign clr_f = both_low && (low_run == RST_LAST);

    // Fault latch with set priority.
    always_ff @(posedge clk) begin
        if (!rst_n)     fault <= 1'b0;
        else if (set_f) fault <= 1'b1;
        else if (clr_f) fault <= 1'b0;
    end

    a_r7_cause_sets: assert property (@(posedge clk) disable iff (!rst_n)
        (bias_low || ovc) |=> fault);

    a_r9_hold_unless_low: assert property (@(posedge clk) disable iff (!rst_n)
        (fault && !both_low) |=> fault);

    a_r10_blank_ignored: assert property (@(posedge clk) disable iff (!rst_n)
        (!fault && !bias_low && !ovc && blank != '0) |=> !fault);

endmodule

// File: rtl/hb_gate_seq.sv
// Half-bridge gate sequencer top: synchronizes all asynchronous inputs,
// filters the two commands, sequences the gates, latches faults and
// captures the comparator threshold select between conduction pulses.
// Assumes one clock domain; all timing parameters are in clock cycles.
module hb_gate_seq #(
    parameter int SYNC_STAGES = 2,
    parameter int FILT_LEN    = 4,
    parameter int DEAD_CYC    = 20,
    parameter int REFRESH_CYC = 35000,
    parameter int REFR_ON_CYC = 100,
    parameter int BLANK_CYC   = DEAD_CYC + 16,
    parameter int FRST_CYC    = 1000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic hs_cmd,
    input  logic ls_cmd,
    input  logic bias_low,
    input  logic ovc_trip,
    input  logic phase_fb,
    input  logic trip_boost,
    output logic hs_gate_en,
    output logic ls_gate_en,
    output logic fault,
    output logic thr_sel
);

    localparam int NCMD = 2;
    localparam int NIN  = NCMD + 4;

    logic [NIN-1:0]  raw_in;
    logic [NIN-1:0]  syn_in;
    logic [NCMD-1:0] cmd_f;

    assign raw_in = {trip_boost, phase_fb, ovc_trip, bias_low, ls_cmd, hs_cmd};

    hbg_sync #(.STAGES(SYNC_STAGES), .W(NIN)) u_sync (
        .clk     (clk),
        .rst_n   (rst_n),
        .d_async (raw_in),
        .q_sync  (syn_in)
    );

    generate
        for (genvar c = 0; c < NCMD; c++) begin : g_filt
            hbg_glitch_filter #(.FILT_LEN(FILT_LEN)) u_filt (
                .clk   (clk),
                .rst_n (rst_n),
                .din   (syn_in[c]),
                .dout  (cmd_f[c])
            );
        end
    endgenerate

    hbg_sequencer #(
        .DEAD_CYC    (DEAD_CYC),
        .REFRESH_CYC (REFRESH_CYC),
        .REFR_ON_CYC (REFR_ON_CYC)
    ) u_seq (
        .clk    (clk),
        .rst_n  (rst_n),
        .cmd_hi (cmd_f[0]),
        .cmd_lo (cmd_f[1]),
        .fault  (fault),
        .hi_en  (hs_gate_en),
        .lo_en  (ls_gate_en)
    );

    hbg_fault_ctl #(
        .BLANK_CYC (BLANK_CYC),
        .FRST_CYC  (FRST_CYC)
    ) u_fault (
        .clk      (clk),
        .rst_n    (rst_n),
        .bias_low (syn_in[2]),
        .ovc      (syn_in[3]),
        .phase    (syn_in[4]),
        .hi_en    (hs_gate_en),
        .lo_en    (ls_gate_en),
        .cmd_hi   (cmd_f[0]),
        .cmd_lo   (cmd_f[1]),
        .fault    (fault)
    );

    // Capture the boost request only while no switch conducts.
    always_ff @(posedge clk) begin
        if (!rst_n)                       thr_sel <= 1'b0;
        else if (!hs_gate_en && !ls_gate_en) thr_sel <= syn_in[5];
    end

    a_r8_fault_gates_off: assert property (@(posedge clk) disable iff (!rst_n)
        fault |=> (!hs_gate_en && !ls_gate_en));

    a_r11_thr_held: assert property (@(posedge clk) disable iff (!rst_n)
        ((hs_gate_en || ls_gate_en) && $past(hs_gate_en || ls_gate_en)) |-> $stable(thr_sel));

endmodule

// File: tb/tb_hb_gate_seq.sv
module tb_hb_gate_seq;

    localparam int CLK_PERIOD  = 10;
    localparam int FILT_LEN    = 4;
    localparam int DEAD_CYC    = 8;
    localparam int REFRESH_CYC = 200;
    localparam int REFR_ON_CYC = 12;
    localparam int BLANK_CYC   = 24;
    localparam int FRST_CYC    = 40;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic hs_cmd = 1'b0, ls_cmd = 1'b0, bias_low = 1'b0, ovc_trip = 1'b0;
    logic trip_boost = 1'b0;
    logic phase_fb;
    logic ph_force = 1'b0;
    logic ph_q = 1'b0;
    logic hs_gate_en, ls_gate_en, fault, thr_sel;

    int errors = 0;
    int checks = 0;
    bit done = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    hb_gate_seq #(
        .SYNC_STAGES (2),
        .FILT_LEN    (FILT_LEN),
        .DEAD_CYC    (DEAD_CYC),
        .REFRESH_CYC (REFRESH_CYC),
        .REFR_ON_CYC (REFR_ON_CYC),
        .BLANK_CYC   (BLANK_CYC),
        .FRST_CYC    (FRST_CYC)
    ) dut (
        .clk        (clk),
        .rst_n      (rst_n),
        .hs_cmd     (hs_cmd),
        .ls_cmd     (ls_cmd),
        .bias_low   (bias_low),
        .ovc_trip   (ovc_trip),
        .phase_fb   (phase_fb),
        .trip_boost (trip_boost),
        .hs_gate_en (hs_gate_en),
        .ls_gate_en (ls_gate_en),
        .fault      (fault),
        .thr_sel    (thr_sel)
    );

    // Output-node model: follows the conducting switch, holds when both off.
    always @(posedge clk) begin
        if (ph_force)        ph_q <= 1'b0;
        else if (hs_gate_en) ph_q <= 1'b1;
        else if (ls_gate_en) ph_q <= 1'b0;
    end
    assign phase_fb = ph_q;

    // Scoreboard of expected {hs, ls, fault, thr}.
    typedef struct {
        string      req;
        logic [3:0] val;
    } exp_t;
    exp_t exp_q[$];

    // Monitor: pop and compare each expected item away from the active edge.
    always @(negedge clk) begin
        while (exp_q.size() > 0) begin
            exp_t e;
            logic [3:0] act;
            e = exp_q.pop_front();
            act = {hs_gate_en, ls_gate_en, fault, thr_sel};
            checks++;
            if (act !== e.val) begin
                errors++;
                $display("FAIL %s: {hs,ls,fault,thr} actual=%b expected=%b", e.req, act, e.val);
            end
        end
    end

    // Stream checks: dead time, exclusivity, refresh pulse shape.
    int off_cnt = DEAD_CYC;
    int hi_len = 0, lo_len = 0;
    int hs_rises = 0, ref_pulses = 0;
    bit prev_hs = 1'b0, prev_ls = 1'b0, lo_is_ref = 1'b0;

    always @(negedge clk) begin
        if (rst_n) begin
            if ((hs_gate_en && !prev_hs) || (ls_gate_en && !prev_ls)) begin
                checks++;
                if (off_cnt < DEAD_CYC) begin
                    errors++;
                    $display("FAIL R3: dead gap actual=%0d expected>=%0d", off_cnt, DEAD_CYC);
                end
            end
            if (hs_gate_en && ls_gate_en) begin
                checks++; errors++;
                $display("FAIL R3: both enables actual=11 expected=not both");
            end
            if (hs_gate_en && !prev_hs) hs_rises++;
            if (ls_gate_en && !prev_ls) lo_is_ref = !ls_cmd;
            if (!hs_gate_en && prev_hs) begin
                checks++;
                if (hi_len > REFRESH_CYC) begin
                    errors++;
                    $display("FAIL R4: hi stint actual=%0d expected<=%0d", hi_len, REFRESH_CYC);
                end
            end
            if (!ls_gate_en && prev_ls && lo_is_ref) begin
                ref_pulses++;
                checks++;
                if (lo_len != REFR_ON_CYC) begin
                    errors++;
                    $display("FAIL R4: refresh pulse actual=%0d expected=%0d", lo_len, REFR_ON_CYC);
                end
            end
            hi_len  = hs_gate_en ? hi_len + 1 : 0;
            lo_len  = ls_gate_en ? lo_len + 1 : 0;
            off_cnt = (hs_gate_en || ls_gate_en) ? 0 : off_cnt + 1;
        end
        prev_hs = hs_gate_en;
        prev_ls = ls_gate_en;
    end

    task automatic cyc(input int n);
        repeat (n) @(posedge clk);
        #1;
    endtask

    task automatic settle();
        cyc(25);
    endtask

    task automatic expect_out(input string req, input logic [3:0] v);
        @(posedge clk); #1;
        exp_q.push_back('{req: req, val: v});
        @(negedge clk); #1;
    endtask

    task automatic check_int(input string req, input int act, input int exp_v, input bit at_least);
        checks++;
        if (at_least ? (act < exp_v) : (act != exp_v)) begin
            errors++;
            $display("FAIL %s: actual=%0d expected=%s%0d", req, act, at_least ? ">=" : "", exp_v);
        end
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    endtask

    // Watchdog: a hung run counts as a failure.
    initial begin
        repeat (150000) @(posedge clk);
        checks++; errors++;
        $display("FAIL watchdog: actual=timeout expected=completion");
        finish_run();
    end

    initial begin
        int base;
        cyc(5);
        rst_n = 1'b1;
        expect_out("R12 reset state", 4'b0000);

        // R1: command mapping
        hs_cmd = 1'b1; settle();
        expect_out("R1 high only", 4'b1000);
        hs_cmd = 1'b0; ls_cmd = 1'b1; settle();
        expect_out("R1 low only", 4'b0100);
        ls_cmd = 1'b0; settle();
        expect_out("R1 none", 4'b0000);

        // R2: glitch rejection and acceptance
        base = hs_rises;
        hs_cmd = 1'b1; cyc(FILT_LEN - 1); hs_cmd = 1'b0; settle();
        check_int("R2 short pulse rejected", hs_rises - base, 0, 1'b0);
        base = hs_rises;
        hs_cmd = 1'b1; cyc(FILT_LEN); hs_cmd = 1'b0; settle();
        check_int("R2 full pulse accepted", hs_rises - base, 1, 1'b0);

        // R5: conflicting commands
        hs_cmd = 1'b1; settle();
        expect_out("R5 before conflict", 4'b1000);
        ls_cmd = 1'b1; settle();
        expect_out("R5 both commanded", 4'b0000);
        ls_cmd = 1'b0; settle();
        expect_out("R5 conflict removed", 4'b1000);
        hs_cmd = 1'b0; settle();

        // R4: forced refresh under continuous high command
        base = ref_pulses;
        hs_cmd = 1'b1; cyc(700);
        check_int("R4 refresh pulses", ref_pulses - base, 2, 1'b1);
        hs_cmd = 1'b0; settle();

        // R6: faster commanded switching restarts the timer
        base = ref_pulses;
        for (int i = 0; i < 5; i++) begin
            hs_cmd = 1'b1; ls_cmd = 1'b0; cyc(120);
            hs_cmd = 1'b0; ls_cmd = 1'b1; cyc(60);
        end
        ls_cmd = 1'b0; settle();
        check_int("R6 no forced refresh", ref_pulses - base, 0, 1'b0);

        // R11: threshold select captured between pulses
        trip_boost = 1'b1; settle();
        hs_cmd = 1'b1; settle();
        expect_out("R11 boost captured", 4'b1001);
        trip_boost = 1'b0; cyc(10);
        expect_out("R11 held during pulse", 4'b1001);
        hs_cmd = 1'b0; settle();
        expect_out("R11 recaptured while off", 4'b0000);

        // R7/R8/R9: overcurrent fault, latch, clear
        hs_cmd = 1'b1; settle();
        expect_out("R1 high before fault", 4'b1000);
        ovc_trip = 1'b1; cyc(6);
        expect_out("R8 overcurrent forces off", 4'b0010);
        ovc_trip = 1'b0; cyc(10);
        expect_out("R7 fault latched", 4'b0010);
        hs_cmd = 1'b0; cyc(20);
        hs_cmd = 1'b1; settle();
        expect_out("R9 short low kept fault", 4'b0010);
        hs_cmd = 1'b0; cyc(FRST_CYC + 20);
        expect_out("R9 fault cleared", 4'b0000);
        hs_cmd = 1'b1; settle();
        expect_out("R9 operation resumes", 4'b1000);
        hs_cmd = 1'b0; settle();

        // R7: bias undervoltage
        ls_cmd = 1'b1; settle();
        expect_out("R1 low before bias", 4'b0100);
        bias_low = 1'b1; cyc(6);
        expect_out("R7 bias low fault", 4'b0010);
        bias_low = 1'b0; ls_cmd = 1'b0; cyc(FRST_CYC + 20);
        expect_out("R9 clear after bias", 4'b0000);

        // R10: blanking window then real mismatch
        ph_force = 1'b1;
        hs_cmd = 1'b1;
        for (int i = 0; i < 60 && !hs_gate_en; i++) cyc(1);
        cyc(10);
        ph_force = 1'b0; cyc(30);
        expect_out("R10 mismatch in window ignored", 4'b1000);
        ph_force = 1'b1; cyc(8);
        expect_out("R10 mismatch trips fault", 4'b0010);
        hs_cmd = 1'b0; ph_force = 1'b0; cyc(FRST_CYC + 20);
        expect_out("R9 clear after phase fault", 4'b0000);

        cyc(5);
        finish_run();
    end

endmodule